// File: doc/BRIEF.md
# Single-wire slave bit timer

This block is the bit-level front end of a slave on an open-drain single-wire bus. It runs from a free-running clock; `TICKS_PER_US` tells it how many clock cycles make one microsecond. It watches the synchronised line level and drives a pull-down enable. Every slot is timed from the master's falling edge. The length of each low period is measured, and that measurement decides two things: whether the low period was a bus reset, and whether fast (overdrive) speed survives the reset.

After a reset the block waits for a short gap and then answers with a presence pulse. It decodes write slots into received bits. In a read slot it holds the line low for the hold time when the bit to send is 0. The command layer above it selects the fast timing set through `od_mode`. The block tells that layer when a reset forces standard speed. Whether a slot is a read or a write is decided at its falling edge, by whether a transmit bit is on offer at that moment.

Top module: `owire_slot_timer`

## Requirements
- R1: While reset is held, and right after it is released, `pull_low`, `rx_valid`, `tx_ready`, `reset_seen` and `od_clear` are all 0.
- R2: A falling edge with `tx_valid` low starts a write slot. The block gives exactly one single-cycle `rx_valid` strobe per write slot. `rx_bit` carries the line level at the sample point: 30 µs after the fall at standard speed, 3 µs in fast mode. A line still low at that point reads as 0, and a line already high reads as 1.
- R3: A falling edge with `tx_valid` high starts a read slot. `tx_ready` pulses for one cycle, which consumes the bit. If `tx_bit` is 0, `pull_low` stays high for the hold time (30 µs standard, 3 µs fast). If `tx_bit` is 1, `pull_low` is never raised. A read slot gives no `rx_valid` strobe.
- R4: At standard speed, a low period of 480 µs or longer is a reset and gives one `reset_seen` pulse when the line rises, with `od_clear` staying 0. A 400 µs low period is not a reset. Both still give their 0 strobe at the sample point.
- R5: In fast mode, a low period from 48 µs up to 80 µs is a reset with `reset_seen` and no `od_clear`, so fast speed is kept.
- R6: In fast mode, a low period longer than 80 µs is a reset, and `od_clear` pulses in the same cycle as `reset_seen`. This holds for the 80–480 µs band as well as for 480 µs and above.
- R7: In fast mode, a low period shorter than 48 µs is not a reset.
- R8: After a reset, once the line is seen high, the block waits tPDH (30 µs standard, 3 µs fast) and then raises `pull_low` for exactly tPDL (120 µs standard, 12 µs fast). `pull_low` is 0 when `reset_seen` fires.
- R9: The falling edge caused by the presence pulse is not taken as a slot, so no `rx_valid` is produced from the block's own pull-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Bus line level (asynchronous) |
| od_mode | input | 1 | 1 selects the fast timing set |
| tx_valid | input | 1 | A bit to send is on offer for the next slot |
| tx_bit | input | 1 | Bit to send in a read slot |
| tx_ready | output | 1 | One-cycle pulse when the offered bit is taken |
| pull_low | output | 1 | Pull-down enable for the bus line |
| rx_valid | output | 1 | One-cycle strobe for a received write bit |
| rx_bit | output | 1 | Received bit value, valid with `rx_valid` |
| reset_seen | output | 1 | One-cycle pulse when a reset is recognised |
| od_clear | output | 1 | One-cycle pulse when a reset forces standard speed |

## Verification
The hardest cases are the three fast-mode reset bands. Only the length of a single low period, measured while `od_mode` is high, tells them apart. The bench holds the line for 30, 60, 200 and 500 µs in fast mode and checks which of `reset_seen` and `od_clear` fire. For each accepted reset it also times the presence pulse to the exact cycle count. Read slots with a 0 bit are the other awkward case, because the master and the block pull the line low together. The bench releases the master early and checks that the line is still held low at mid-slot.

// File: rtl/owire_slot_timer.sv
`timescale 1ns/1ps
module owire_slot_timer #(
  parameter int TICKS_PER_US = 200,
  parameter int RST_US       = 480,
  parameter int OD_KEEP_US   = 80,
  parameter int PDH_US       = 30,
  parameter int PDL_US       = 120,
  parameter int SMP_US       = 30,
  parameter int HLD_US       = 30,
  parameter int OD_DIV       = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic od_mode,
  input  logic tx_valid,
  input  logic tx_bit,
  output logic tx_ready,
  output logic pull_low,
  output logic rx_valid,
  output logic rx_bit,
  output logic reset_seen,
  output logic od_clear
);
  localparam int C_RST = RST_US * TICKS_PER_US;
  localparam int CW    = $clog2(C_RST + 2);

  localparam logic [CW-1:0] K_RST     = CW'(C_RST);
  localparam logic [CW-1:0] K_RST_OD  = CW'((RST_US / OD_DIV) * TICKS_PER_US);
  localparam logic [CW-1:0] K_KEEP    = CW'(OD_KEEP_US * TICKS_PER_US);
  localparam logic [CW-1:0] K_PDH     = CW'(PDH_US * TICKS_PER_US);
  localparam logic [CW-1:0] K_PDH_OD  = CW'((PDH_US / OD_DIV) * TICKS_PER_US);
  localparam logic [CW-1:0] K_PDL     = CW'(PDL_US * TICKS_PER_US);
  localparam logic [CW-1:0] K_PDL_OD  = CW'((PDL_US / OD_DIV) * TICKS_PER_US);
  localparam logic [CW-1:0] K_SMP     = CW'(SMP_US * TICKS_PER_US);
  localparam logic [CW-1:0] K_SMP_OD  = CW'((SMP_US / OD_DIV) * TICKS_PER_US);
  localparam logic [CW-1:0] K_HLD     = CW'(HLD_US * TICKS_PER_US);
  localparam logic [CW-1:0] K_HLD_OD  = CW'((HLD_US / OD_DIV) * TICKS_PER_US);
  localparam logic [CW-1:0] K_MAX     = '1;

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_PDH, S_PDL, S_REC} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          sync0, line_s, line_q;
  logic          rd_slot, rd_zero;

  logic [CW-1:0] t_pdh, t_pdl, t_smp, t_hld, slot_end;
  logic          fall, low_over, is_rst, drop_od;

  assign t_pdh    = od_mode ? K_PDH_OD : K_PDH;
  assign t_pdl    = od_mode ? K_PDL_OD : K_PDL;
  assign t_smp    = od_mode ? K_SMP_OD : K_SMP;
  assign t_hld    = od_mode ? K_HLD_OD : K_HLD;
  assign slot_end = rd_slot ? t_hld : t_smp;

  assign fall     = line_q & ~line_s;
  assign low_over = (state == S_LOW) && line_s && (cnt >= slot_end);
  assign is_rst   = od_mode ? (cnt >= K_RST_OD) : (cnt >= K_RST);
  assign drop_od  = od_mode && (cnt > K_KEEP);

  assign tx_ready = (state == S_IDLE) && fall && tx_valid;
  assign pull_low = (state == S_PDL) ||
                    ((state == S_LOW) && rd_zero && (cnt < t_hld));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync0      <= 1'b1;
      line_s     <= 1'b1;
      line_q     <= 1'b1;
      state      <= S_IDLE;
      cnt        <= '0;
      rd_slot    <= 1'b0;
      rd_zero    <= 1'b0;
      rx_valid   <= 1'b0;
      rx_bit     <= 1'b0;
      reset_seen <= 1'b0;
      od_clear   <= 1'b0;
    end else begin
      sync0      <= line_in;
      line_s     <= sync0;
      line_q     <= line_s;
      rx_valid   <= 1'b0;
      reset_seen <= 1'b0;
      od_clear   <= 1'b0;
      cnt        <= (cnt == K_MAX) ? cnt : cnt + 1'b1;
      case (state)
        S_IDLE: if (fall) begin
          state   <= S_LOW;
          cnt     <= '0;
          rd_slot <= tx_valid;
          rd_zero <= tx_valid & ~tx_bit;
        end
        S_LOW: begin
          if (!rd_slot && cnt == t_smp - 1'b1) begin
            rx_valid <= 1'b1;
            rx_bit   <= line_s;
          end
          if (low_over) begin
            cnt     <= '0;
            rd_slot <= 1'b0;
            rd_zero <= 1'b0;
            if (is_rst) begin
              reset_seen <= 1'b1;
              od_clear   <= drop_od;
              state      <= S_PDH;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_PDH: begin
          if (fall) begin
            state   <= S_LOW;
            cnt     <= '0;
            rd_slot <= 1'b0;
            rd_zero <= 1'b0;
          end else if (cnt == t_pdh - 1'b1) begin
            state <= S_PDL;
            cnt   <= '0;
          end
        end
        S_PDL: if (cnt == t_pdl - 1'b1) state <= S_REC;
        S_REC: if (line_s) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/owire_slot_timer_chk.sv
`timescale 1ns/1ps
module owire_slot_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic od_mode,
  input logic pull_low,
  input logic rx_valid,
  input logic reset_seen,
  input logic od_clear
);
  p_rx_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_clear_with_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    od_clear |-> reset_seen);

  p_clear_from_od_r6: assert property (@(posedge clk) disable iff (!rst_n)
    od_clear |-> $past(od_mode));

  p_quiet_at_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_seen |-> !pull_low);

  p_rx_not_own_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !$past(pull_low));
endmodule

bind owire_slot_timer owire_slot_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .od_mode(od_mode), .pull_low(pull_low),
  .rx_valid(rx_valid), .reset_seen(reset_seen), .od_clear(od_clear)
);

// File: tb/owire_slot_timer_tb.sv
`timescale 1ns/1ps
module owire_slot_timer_tb;
  localparam int TPU = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_low = 1'b0;
  logic od_mode = 1'b0;
  logic tx_valid = 1'b0;
  logic tx_bit = 1'b0;
  logic tx_ready, pull_low, rx_valid, rx_bit, reset_seen, od_clear;
  logic line_in;

  int nchk = 0, nerr = 0;
  int n_rx = 0, n_rst = 0, n_clr = 0, n_rdy = 0, n_pull = 0;
  logic last_bit = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign line_in = ~(m_low | pull_low);

  owire_slot_timer #(.TICKS_PER_US(TPU)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .od_mode(od_mode),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_ready(tx_ready),
    .pull_low(pull_low), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .reset_seen(reset_seen), .od_clear(od_clear)
  );

  always @(negedge clk) begin
    if (rx_valid) begin n_rx++; last_bit = rx_bit; end
    if (reset_seen) n_rst++;
    if (od_clear) n_clr++;
    if (tx_ready) n_rdy++;
    if (pull_low) n_pull++;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic wait_us(input int us);
    repeat (us * TPU) @(negedge clk);
  endtask

  task automatic t_reset_state;
    chk(!pull_low && !rx_valid && !tx_ready && !reset_seen && !od_clear,
        "R1", "outputs during reset", int'(pull_low | rx_valid | reset_seen), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!pull_low && !rx_valid && !reset_seen && !od_clear,
        "R1", "outputs after reset", int'(pull_low | rx_valid | reset_seen), 0);
  endtask

  task automatic t_write(input bit od, input int low_us, input int slot_us,
                         input bit exp_bit);
    int rx0, rst0;
    od_mode = od; rx0 = n_rx; rst0 = n_rst;
    m_low = 1'b1; wait_us(low_us);
    m_low = 1'b0; wait_us(slot_us - low_us);
    chk(n_rx - rx0 == 1, "R2", "write strobes", n_rx - rx0, 1);
    chk(last_bit == exp_bit, "R2", "write bit", int'(last_bit), int'(exp_bit));
    chk(n_rst == rst0, "R2", "no reset in slot", n_rst - rst0, 0);
  endtask

  task automatic t_read(input bit od, input bit b);
    int rx0, rdy0, p0;
    od_mode = od; rx0 = n_rx; rdy0 = n_rdy; p0 = n_pull;
    tx_valid = 1'b1; tx_bit = b;
    @(negedge clk); m_low = 1'b1;
    repeat (4) @(negedge clk);
    m_low = 1'b0;
    repeat (od ? 4 : 56) @(negedge clk);
    chk(pull_low == !b, "R3", "pull mid-slot", int'(pull_low), int'(!b));
    chk(n_rdy - rdy0 == 1, "R3", "ready pulses", n_rdy - rdy0, 1);
    tx_valid = 1'b0;
    repeat (od ? 30 : 160) @(negedge clk);
    chk(!pull_low, "R3", "released after hold", int'(pull_low), 0);
    if (b) chk(n_pull == p0, "R3", "no pull for 1", n_pull - p0, 0);
    chk(n_rx == rx0, "R3", "no rx in read", n_rx - rx0, 0);
  endtask

  task automatic t_low(input bit od, input int low_us, input bit exp_rst,
                       input bit exp_clr, input string rq);
    int rx0, rst0, clr0, p0, k, w, pdh, pdl;
    pdh = (od ? 3 : 30) * TPU;
    pdl = (od ? 12 : 120) * TPU;
    od_mode = od; rx0 = n_rx; rst0 = n_rst; clr0 = n_clr;
    m_low = 1'b1; wait_us(low_us);
    m_low = 1'b0;
    p0 = n_pull;
    k = 0;
    while (!pull_low && k < pdh + 40) begin @(negedge clk); k++; end
    if (exp_rst) begin
      chk(k >= pdh + 2 && k <= pdh + 4, "R8", "presence delay", k, pdh + 3);
      w = 0;
      while (pull_low && w < pdl + 40) begin @(negedge clk); w++; end
      chk(w == pdl, "R8", "presence width", w, pdl);
    end else begin
      chk(n_pull == p0, rq, "no presence", n_pull - p0, 0);
    end
    wait_us(20);
    chk(n_rst - rst0 == int'(exp_rst), rq, "reset pulses", n_rst - rst0, int'(exp_rst));
    chk(n_clr - clr0 == int'(exp_clr), rq, "speed clear pulses", n_clr - clr0, int'(exp_clr));
    chk(n_rx - rx0 == 1, "R9", "only the 0 strobe", n_rx - rx0, 1);
    chk(last_bit == 1'b0, "R4", "long low reads 0", int'(last_bit), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset_state();
    wait_us(10);
    t_write(1'b0, 6, 70, 1'b1);
    t_write(1'b0, 60, 70, 1'b0);
    t_write(1'b1, 1, 10, 1'b1);
    t_write(1'b1, 8, 10, 1'b0);
    t_read(1'b0, 1'b0);
    t_read(1'b0, 1'b1);
    t_read(1'b1, 1'b0);
    t_read(1'b1, 1'b1);
    t_low(1'b0, 500, 1'b1, 1'b0, "R4");
    t_low(1'b0, 400, 1'b0, 1'b0, "R4");
    t_low(1'b1, 60, 1'b1, 1'b0, "R5");
    t_low(1'b1, 200, 1'b1, 1'b1, "R6");
    t_low(1'b1, 500, 1'b1, 1'b1, "R6");
    t_low(1'b1, 30, 1'b0, 1'b0, "R7");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule